// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller with Deferred Requests

This block keeps the pending-interrupt flags and the interrupt enable mask for a small processor, and decides which source is serviced next. Each interrupt source can raise a request in one of two ways. An immediate request lands in the flag register at the next clock edge. A deferred request models a source that fires between processor clock edges. It is parked for one cycle in a separate pending vector and folded into the flags on the following edge. While parked, it already shows in the flag readback. It also counts toward dispatch, but only while the processor is running.

The processor reads and writes the flag and enable registers through a single register port. It receives a one-hot selected source, the matching vector address and a wake signal. A two-state machine tracks whether the processor is halted. The states are RUN and HALTED. The transition RUN to HALTED (halt entry) is taken when a halt is requested and no candidate interrupt exists. The transition HALTED to RUN (wake release) is taken when the candidate set becomes nonzero.

The source bits are: bit 0 vertical blank, bit 1 display status, bit 2 timer, bit 3 serial, bit 4 keypad.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flags, the enable mask and the pending vector are all zero, the state is RUN, and no source is selected.
- R2: Register select 0 is the flag register. Its readback has bits 7..5 at one and bits 4..0 equal to the flags ORed with the pending vector. Register select 1 is the enable mask, which reads back with bits 7..5 at zero.
- R3: An immediate request bit sets the matching flag at the next clock edge.
- R4: A deferred request bit appears in the pending vector at the next edge, and so in the readback. At the edge after that it is moved into the flags and leaves the pending vector.
- R5: A write to the flag register loads bits 4..0 of the write data, ORed with the immediate requests of that cycle. The write discards the whole pending vector. Deferred requests arriving in the same cycle are still parked.
- R6: A write to the enable register loads bits 4..0 of the write data at the next edge.
- R7: The candidate set is enable AND flags. In state RUN, enable AND pending is added to it. The wake output is high exactly when the candidate set is nonzero.
- R8: The selected source is the lowest set bit of the candidate set, given one-hot. The valid output marks a nonempty set. The vector address is 0x40 + 8 x bit index.
- R9: An acknowledge clears the selected source in the flags and stops its pending bit from folding in. An immediate request for the same source in the same cycle wins and leaves the flag set. A flag write in the same cycle takes precedence over the acknowledge.
- R10: Halt entry happens at the next edge when the halt request is high and wake is low. Wake release happens at the next edge when wake is high while in HALTED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_now | input | 5 | Immediate request pulses, one per source |
| req_late | input | 5 | Deferred request pulses, one per source |
| reg_sel | input | 1 | Register select: 0 flags, 1 enable |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the selected register |
| halt_req | input | 1 | Processor asks to halt |
| ack | input | 1 | Processor accepts the selected source |
| halted | output | 1 | High in state HALTED |
| wake | output | 1 | Candidate set is nonzero |
| irq_valid | output | 1 | A source is selected |
| irq_sel | output | 5 | One-hot selected source |
| irq_vec | output | 8 | Vector address of the selected source |

## Verification
The embedded properties check several rules on every cycle. Immediate requests always land. A flag write always empties the pending vector. An acknowledge without a competing request clears its flag. The selection is at most one-hot. The flag readback padding is fixed. Halt entry and wake release follow wake. Other behaviour only shows when a scenario lines events up, and the directed scenarios and the seeded random run against a reference model cover it. That includes the two-step travel of a deferred request. It also includes the one-cycle-late wake when a halted processor has only a parked request. The interplay of write, acknowledge and request in the same cycle and the full vector table are covered the same way.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_t;
endpackage

// File: rtl/irqf_prio.sv
module irqf_prio #(
    parameter int N    = 5,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    cand,
    output logic [N-1:0]    onehot,
    output logic            valid,
    output logic [IDXW-1:0] idx
);
    logic [N:0] below;

    assign below[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign below[i+1] = below[i] | cand[i];
        assign onehot[i]  = cand[i] & ~below[i];
    end
    assign valid = below[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/irqf_flags.sv
module irqf_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_now,
    input  logic [N-1:0] req_late,
    input  logic         wr_flags,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] ack_mask,
    output logic [N-1:0] flags,
    output logic [N-1:0] pend,
    output logic [N-1:0] en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            pend  <= '0;
            en    <= '0;
        end else begin
            pend <= req_late;
            if (wr_flags) begin
                flags <= wdata | req_now;
            end else begin
                flags <= ((flags | pend) & ~ack_mask) | req_now;
            end
            if (wr_en) en <= wdata;
        end
    end

    // R3
    req_now_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_now != '0) |=> ((flags & $past(req_now)) == $past(req_now)));

    // R5
    wr_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flags |=> (pend == $past(req_late)));

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_mask != '0) && !wr_flags && ((ack_mask & req_now) == '0))
        |=> ((flags & $past(ack_mask)) == '0));
endmodule

// File: rtl/irqf_halt_fsm.sv
module irqf_halt_fsm
    import irqf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic wake,
    output logic halted
);
    run_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (halt_req && !wake) state_nx = ST_HALT;
            ST_HALT: if (wake)              state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    assign halted = (state == ST_HALT);

    // R10
    wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && wake) |=> !halted);

    // R10
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && halt_req && !wake) |=> halted);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
    parameter int         NSRC     = 5,
    parameter int         DW       = 8,
    parameter logic [7:0] VEC_BASE = 8'h40,
    parameter int         VEC_STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_now,
    input  logic [NSRC-1:0] req_late,
    input  logic            reg_sel,
    input  logic            reg_wr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            halt_req,
    input  logic            ack,
    output logic            halted,
    output logic            wake,
    output logic            irq_valid,
    output logic [NSRC-1:0] irq_sel,
    output logic [7:0]      irq_vec
);
    localparam int PADW = DW - NSRC;
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] flags, pend, en, cand, ack_mask;
    logic [IDXW-1:0] idx;
    logic            wr_flags, wr_en;
    logic [PADW-1:0] unused_wdata;

    assign wr_flags     = reg_wr && !reg_sel;
    assign wr_en        = reg_wr &&  reg_sel;
    assign ack_mask     = ack ? irq_sel : '0;
    assign unused_wdata = reg_wdata[DW-1:NSRC];

    irqf_flags #(.N(NSRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_now  (req_now),
        .req_late (req_late),
        .wr_flags (wr_flags),
        .wr_en    (wr_en),
        .wdata    (reg_wdata[NSRC-1:0]),
        .ack_mask (ack_mask),
        .flags    (flags),
        .pend     (pend),
        .en       (en)
    );

    assign cand = (en & flags) | (halted ? '0 : (en & pend));
    assign wake = |cand;

    irqf_prio #(.N(NSRC), .IDXW(IDXW)) u_prio (
        .cand   (cand),
        .onehot (irq_sel),
        .valid  (irq_valid),
        .idx    (idx)
    );

    assign irq_vec = VEC_BASE + 8'(idx) * 8'(VEC_STEP);

    irqf_halt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (halt_req),
        .wake     (wake),
        .halted   (halted)
    );

    assign reg_rdata = reg_sel ? {{PADW{1'b0}}, en}
                               : {{PADW{1'b1}}, (flags | pend)};

    // R2
    if_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[DW-1:NSRC] == {PADW{1'b1}}));

    // R8
    one_hot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_sel) && (irq_valid == (irq_sel != '0)));

    // R7
    halt_masks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && ((en & flags) == '0)) |-> !wake);
endmodule

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req_now = '0, req_late = '0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       halt_req = 1'b0, ack = 1'b0;
    logic       halted, wake, irq_valid;
    logic [4:0] irq_sel;
    logic [7:0] irq_vec;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [4:0] m_if = '0, m_pend = '0, m_ie = '0;
    logic       m_halt = 1'b0;

    always #10 clk = ~clk;

    irq_flag_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_now(req_now), .req_late(req_late),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .halt_req(halt_req), .ack(ack),
        .halted(halted), .wake(wake), .irq_valid(irq_valid),
        .irq_sel(irq_sel), .irq_vec(irq_vec)
    );

    function automatic logic [4:0] exp_cand();
        return (m_ie & m_if) | (m_halt ? 5'd0 : (m_ie & m_pend));
    endfunction

    function automatic logic [4:0] lowest(input logic [4:0] c);
        for (int i = 0; i < 5; i++) if (c[i]) return 5'(1 << i);
        return 5'd0;
    endfunction

    function automatic logic [7:0] exp_vec(input logic [4:0] c);
        for (int i = 0; i < 5; i++) if (c[i]) return 8'h40 + 8'(8 * i);
        return 8'h40;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        logic [4:0] c;
        c = exp_cand();
        if (reg_sel) check({tag, " R2 enable readback"}, reg_rdata, {3'b000, m_ie});
        else         check({tag, " R2 flag readback"}, reg_rdata, {3'b111, m_if | m_pend});
        check({tag, " R7 wake"}, wake, c != 0);
        check({tag, " R8 select"}, irq_sel, lowest(c));
        check({tag, " R8 valid"}, irq_valid, c != 0);
        if (c != 0) check({tag, " R8 vector"}, irq_vec, exp_vec(c));
        check({tag, " R10 halted"}, halted, m_halt);
    endtask

    task automatic step(input string tag, input logic [4:0] now, input logic [4:0] late,
                        input logic sel, input logic wr, input logic [7:0] wd,
                        input logic hr, input logic ak);
        logic [4:0] c, am, n_if, n_pend, n_ie;
        logic       n_halt;
        @(negedge clk);
        req_now = now; req_late = late; reg_sel = sel; reg_wr = wr;
        reg_wdata = wd; halt_req = hr; ack = ak;
        #2;
        check_outputs(tag);
        c  = exp_cand();
        am = ak ? lowest(c) : 5'd0;
        n_pend = late;
        if (wr && !sel) n_if = wd[4:0] | now;
        else            n_if = ((m_if | m_pend) & ~am) | now;
        n_ie = (wr && sel) ? wd[4:0] : m_ie;
        n_halt = m_halt;
        if (!m_halt && hr && c == 0) n_halt = 1'b1;
        if (m_halt && c != 0)        n_halt = 1'b0;
        @(posedge clk);
        m_if = n_if; m_pend = n_pend; m_ie = n_ie; m_halt = n_halt;
    endtask

    task automatic idle(input string tag);
        step(tag, 5'd0, 5'd0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        #2;
        check("R1 flag readback", reg_rdata, 8'hE0);
        check("R1 valid", irq_valid, 0);
        check("R1 halted", halted, 0);
        check("R1 wake", wake, 0);
        // R6: enable all sources
        step("R6", 5'd0, 5'd0, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0);
        idle("R6");
        step("R6 readback", 5'd0, 5'd0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
        // R3: immediate timer request lands next edge
        step("R3", 5'b00100, 5'd0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        idle("R3");
        // R9: ack clears timer
        step("R9 ack", 5'd0, 5'd0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1);
        idle("R9 after ack");
        // R9: ack with simultaneous request for same source keeps it
        step("R9", 5'b00010, 5'd0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        step("R9 race", 5'b00010, 5'd0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1);
        idle("R9 race kept");
        step("R9 clear", 5'd0, 5'd0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1);
        // R4: deferred request visible early, then folded
        step("R4", 5'd0, 5'b10000, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        idle("R4 parked");
        idle("R4 folded");
        step("R4 clear", 5'd0, 5'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
        // R5: write discards pending, same-cycle deferred kept
        step("R5 park", 5'd0, 5'b00001, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        step("R5 write", 5'b01000, 5'b00100, 1'b0, 1'b1, 8'h02, 1'b0, 1'b0);
        idle("R5 after");
        idle("R5 fold");
        step("R5 clear", 5'd0, 5'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
        // R10: halt entry, then parked-only request wakes one cycle late
        step("R10 enter", 5'd0, 5'd0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0);
        step("R10 park", 5'd0, 5'b00001, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        idle("R7 halted masks pend");
        idle("R10 wake");
        idle("R10 run");
        step("R10 clear", 5'd0, 5'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
        // R8: all vectors, walking acks
        step("R8 all", 5'b11111, 5'd0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) step("R8 walk", 5'd0, 5'd0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [4:0] rn, rl;
            logic rs, rw, rh, ra;
            rn = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
            rl = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
            rs = 1'($urandom);
            rw = ($urandom % 8 == 0);
            rh = ($urandom % 3 == 0);
            ra = ($urandom % 3 == 0);
            step("rand", rn, rl, rs, rw, 8'($urandom), rh, ra);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule